// File: doc/BRIEF.md
# Byte-Wide to Nibble-Wide Double-Rate Ethernet Transmit Adapter

This block sits between a gigabit MAC transmit port that presents one byte per clock (with separate enable and error strobes) and a reduced-pin PHY link that moves four data wires and one control wire on both clock edges. On every rising edge of the transmit clock it captures the byte, the enable and the error. During the following high half of the clock it drives the low nibble and the enable. During the low half it drives the high nibble and the exclusive-OR of enable and error. It also forwards a copy of the clock that is aligned with the data.

The link runs at 125 MHz for 1 Gb/s, 25 MHz for 100 Mb/s and 2.5 MHz for 10 Mb/s. The speed select does not change the timing. It only chooses the content of the low half. At the two slower rates only the low nibble of each input byte carries data, and that nibble is repeated in both halves. The byte stream has no valid/ready handshake: the wire format cannot stall, so the source must offer a byte (or idle) on every clock and gets no back-pressure. Each output is a pair of rising-edge registers (one value for the high half, one for the low half) selected by the clock level, so no dedicated double-rate output cell is needed.

Top module: `gmii_rgmii_tx`

## Requirements
- R1: In the high half of each clock, rgmii_txd equals tx_byte[3:0] as sampled at the most recent rising edge, so the output lags the input by exactly one clock.
- R2: When speed_sel[1] is 1 (2'b10 or 2'b11, 1 Gb/s), rgmii_txd in the low half equals tx_byte[7:4] sampled at the most recent rising edge.
- R3: In the high half, rgmii_ctl equals tx_en sampled at the most recent rising edge.
- R4: In the low half, rgmii_ctl equals tx_en XOR tx_er from that edge: idle gives 0/0, data gives 1/0, an error inside a frame gives 1/1, and error with enable low gives 0/1.
- R5: Out of reset, rgmii_txc is 1 in the high half and 0 in the low half of every clock.
- R6: When speed_sel is 2'b00 (10 Mb/s) or 2'b01 (100 Mb/s), rgmii_txd in the low half again equals tx_byte[3:0], and tx_byte[7:4] has no effect on any output.
- R7: While rst_n is low (asynchronous, active low), rgmii_txd, rgmii_ctl and rgmii_txc are all 0 in both halves of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock (125, 25 or 2.5 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | 00: 10 Mb/s, 01: 100 Mb/s, 1x: 1 Gb/s |
| tx_byte | input | 8 | Transmit byte from the MAC |
| tx_en | input | 1 | Transmit enable |
| tx_er | input | 1 | Transmit error |
| rgmii_txc | output | 1 | Forwarded clock, aligned with the data |
| rgmii_txd | output | 4 | Double-rate data nibble |
| rgmii_ctl | output | 1 | Double-rate control: enable, then enable XOR error |

## Verification
The assertions assume that tx_byte, tx_en, tx_er and speed_sel are settled around every rising edge. They also assume that reset is released away from a rising edge, so every captured value belongs to a single clock. The stimulus changes all inputs, including speed_sel, only in the low half of the clock, after the low-half sample is taken. It releases and applies reset in the same low-half window. Within those rules the speed select and the enable/error pair may change on every byte, and idle-with-error is driven as freely as error-inside-frame.

// File: rtl/gmii_rgmii_pkg.sv
package gmii_rgmii_pkg;
  typedef enum logic [1:0] {
    SPD_10M   = 2'b00,
    SPD_100M  = 2'b01,
    SPD_1G    = 2'b10,
    SPD_1G_AL = 2'b11
  } speed_e;

  // Upper bit set means the full-rate byte mode.
  function automatic logic is_full_rate(speed_e s);
    return s[1];
  endfunction
endpackage

// File: rtl/rgmii_lane_map.sv
module rgmii_lane_map
  import gmii_rgmii_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] byte_in,
  input  logic              en_in,
  input  logic              er_in,
  input  speed_e            speed_in,
  output logic [NIB_W-1:0]  nib_hi_half,
  output logic [NIB_W-1:0]  nib_lo_half,
  output logic              ctl_hi_half,
  output logic              ctl_lo_half
);
  always_comb begin
    nib_hi_half = byte_in[NIB_W-1:0];
    // Slow rates repeat the low nibble in the second half.
    nib_lo_half = is_full_rate(speed_in) ? byte_in[DATA_W-1:NIB_W]
                                         : byte_in[NIB_W-1:0];
    ctl_hi_half = en_in;
    ctl_lo_half = en_in ^ er_in;
  end
endmodule

// File: rtl/rgmii_ddr_bit.sv
module rgmii_ddr_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_d,
  input  logic lo_d,
  output logic hi_q,
  output logic lo_q,
  output logic pin
);
  // Both halves are captured on the rising edge; the level picks one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign pin = clk ? hi_q : lo_q;
endmodule

// File: rtl/gmii_rgmii_tx.sv
module gmii_rgmii_tx
  import gmii_rgmii_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed_sel,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_en,
  input  logic              tx_er,
  output logic              rgmii_txc,
  output logic [NIB_W-1:0]  rgmii_txd,
  output logic              rgmii_ctl
);
  logic [NIB_W-1:0] map_hi, map_lo;
  logic             map_ctl_hi, map_ctl_lo;
  logic [NIB_W-1:0] q_hi_d, q_lo_d;
  logic             q_hi_c, q_lo_c;
  logic             clk_hi_q, clk_lo_q;

  rgmii_lane_map #(.DATA_W(DATA_W)) map_i (
    .byte_in     (tx_byte),
    .en_in       (tx_en),
    .er_in       (tx_er),
    .speed_in    (speed_e'(speed_sel)),
    .nib_hi_half (map_hi),
    .nib_lo_half (map_lo),
    .ctl_hi_half (map_ctl_hi),
    .ctl_lo_half (map_ctl_lo)
  );

  for (genvar b = 0; b < NIB_W; b++) begin : g_data
    rgmii_ddr_bit cell_i (
      .clk  (clk),
      .rst_n(rst_n),
      .hi_d (map_hi[b]),
      .lo_d (map_lo[b]),
      .hi_q (q_hi_d[b]),
      .lo_q (q_lo_d[b]),
      .pin  (rgmii_txd[b])
    );
  end

  rgmii_ddr_bit ctl_cell_i (
    .clk  (clk),
    .rst_n(rst_n),
    .hi_d (map_ctl_hi),
    .lo_d (map_ctl_lo),
    .hi_q (q_hi_c),
    .lo_q (q_lo_c),
    .pin  (rgmii_ctl)
  );

  // Forwarded clock goes through the same cell type as the data, so it stays aligned.
  rgmii_ddr_bit clk_cell_i (
    .clk  (clk),
    .rst_n(rst_n),
    .hi_d (1'b1),
    .lo_d (1'b0),
    .hi_q (clk_hi_q),
    .lo_q (clk_lo_q),
    .pin  (rgmii_txc)
  );
endmodule

// File: rtl/gmii_rgmii_tx_chk.sv
module gmii_rgmii_tx_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       speed_sel,
  input logic [2*NIB_W-1:0] tx_byte,
  input logic             tx_en,
  input logic             tx_er,
  input logic             rgmii_txc,
  input logic [NIB_W-1:0] rgmii_txd,
  input logic             rgmii_ctl,
  input logic [NIB_W-1:0] q_hi_d,
  input logic [NIB_W-1:0] q_lo_d,
  input logic             q_hi_c,
  input logic             q_lo_c
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_hi_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    q_hi_d == $past(tx_byte[NIB_W-1:0]));

  p_lo_nibble_full_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(speed_sel[1]) |-> q_lo_d == $past(tx_byte[2*NIB_W-1:NIB_W]));

  p_ctl_enable_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    q_hi_c == $past(tx_en));

  p_ctl_fold_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    q_lo_c == ($past(tx_en) != $past(tx_er)));

  p_slow_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(speed_sel[1]) |-> q_lo_d == q_hi_d);

  // R5 and R7: pin levels in the low half
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r7: assert (rgmii_txd == '0 && !rgmii_ctl && !rgmii_txc);
    end else if (armed) begin
      p_clk_low_r5: assert (!rgmii_txc);
    end
  end
endmodule

bind gmii_rgmii_tx gmii_rgmii_tx_chk #(.NIB_W(NIB_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .speed_sel(speed_sel),
  .tx_byte  (tx_byte),
  .tx_en    (tx_en),
  .tx_er    (tx_er),
  .rgmii_txc(rgmii_txc),
  .rgmii_txd(rgmii_txd),
  .rgmii_ctl(rgmii_ctl),
  .q_hi_d   (q_hi_d),
  .q_lo_d   (q_lo_d),
  .q_hi_c   (q_hi_c),
  .q_lo_c   (q_lo_c)
);

// File: tb/gmii_rgmii_tx_tb_top.sv
`timescale 1ns/1ps
module gmii_rgmii_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [1:0] speed_sel = 2'b10;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic       rgmii_txc;
  logic [3:0] rgmii_txd;
  logic       rgmii_ctl;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gmii_rgmii_tx dut_i (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .tx_byte(tx_byte),
    .tx_en(tx_en), .tx_er(tx_er), .rgmii_txc(rgmii_txc),
    .rgmii_txd(rgmii_txd), .rgmii_ctl(rgmii_ctl)
  );

  // Packed view {txc, txd, ctl}
  function automatic logic [5:0] exp_hi(logic [7:0] d, logic en);
    return {1'b1, d[3:0], en};
  endfunction

  function automatic logic [5:0] exp_lo(logic [7:0] d, logic en, logic er, logic [1:0] s);
    logic [3:0] n;
    n = s[1] ? d[7:4] : d[3:0];
    return {1'b0, n, en ^ er};
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one byte in the low half, then check both halves of the next clock.
  task automatic step(logic [7:0] d, logic en, logic er, logic [1:0] s);
    tx_byte = d; tx_en = en; tx_er = er; speed_sel = s;
    @(posedge clk);
    #5 check("R1 R3 R5 high half", {rgmii_txc, rgmii_txd, rgmii_ctl}, exp_hi(d, en));
    #7 check(s[1] ? "R2 R4 R5 low half" : "R6 R4 R5 low half",
             {rgmii_txc, rgmii_txd, rgmii_ctl}, exp_lo(d, en, er, s));
  endtask

  initial begin
    #1 rst_n = 1'b0;
    tx_byte = 8'hA5; tx_en = 1'b1; tx_er = 1'b1;
    @(posedge clk);
    #5 check("R7 reset high half", {rgmii_txc, rgmii_txd, rgmii_ctl}, 6'b0);
    #7 check("R7 reset low half", {rgmii_txc, rgmii_txd, rgmii_ctl}, 6'b0);
    rst_n = 1'b1;

    // Directed: the four enable/error pairs at full rate (R4)
    step(8'h00, 1'b0, 1'b0, 2'b10);
    step(8'h5D, 1'b1, 1'b0, 2'b10);
    step(8'hC3, 1'b1, 1'b1, 2'b11);
    step(8'h0F, 1'b0, 1'b1, 2'b10);
    // Directed: upper nibble ignored at slow rates (R6)
    step(8'hF0, 1'b1, 1'b0, 2'b00);
    step(8'h9A, 1'b1, 1'b1, 2'b01);
    step(8'hFF, 1'b0, 1'b1, 2'b00);
    // Speed change on adjacent bytes
    step(8'h7E, 1'b1, 1'b0, 2'b10);
    step(8'h7E, 1'b1, 1'b0, 2'b01);

    // Reset in the middle of traffic (R7)
    tx_byte = 8'hB6; tx_en = 1'b1; tx_er = 1'b0;
    rst_n = 1'b0;
    #1 check("R7 async reset", {rgmii_txc, rgmii_txd, rgmii_ctl}, 6'b0);
    @(posedge clk);
    #5 check("R7 held high half", {rgmii_txc, rgmii_txd, rgmii_ctl}, 6'b0);
    #7 check("R7 held low half", {rgmii_txc, rgmii_txd, rgmii_ctl}, 6'b0);
    rst_n = 1'b1;

    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      logic [1:0] s;
      logic en, er;
      d  = 8'($urandom);
      s  = 2'($urandom);
      en = 1'($urandom);
      er = ($urandom % 4) == 0;
      step(d, en, er, s);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule